// File: doc/BRIEF.md
# Serial Switch-Command and Fault-Report Port

This block is the serial slave front end of a sixteen-channel low-side switch controller. An external host lowers the chip select, clocks a 24-bit command word into the block, and raises chip select again. The block applies the command's sixteen channel-enable bits to the output-enable register only if exactly 24 bits arrived. Other frame lengths leave the enables as they were.

On each chip-select assertion the block takes a snapshot of the channel fault flags and the overvoltage flag. It then returns that snapshot to the host on the serial output during the same frame, most significant bit first. The serial pins are brought into the fast system clock domain through synchronisers, and all serial edges are detected there. The serial clock must therefore run well below the system clock.

Top module: `sw_serial_port`

## Requirements
- R1: When chip select rises after exactly 24 data bits, bits 15..0 of the received word are loaded into `out_en`, with word bit k driving channel k. Bits 23..16 of the word are not applied.
- R2: `sdi` is sampled on each falling `sclk` edge, and the first sampled bit becomes word bit 23 (MSB first).
- R3: `sdo` changes only on rising `sclk` edges. The first rising edge of a frame presents status bit 23, and each following edge presents the next lower bit.
- R4: The status word is captured when chip select falls. Later changes of the fault inputs do not alter the word sent in that frame.
- R5: The status word layout is: bit 23 = any-fault, bit 22 = overvoltage, bits 21..16 = 0, bits 15..0 = fault flags of channels 15..0.
- R6: Any-fault is 1 when any channel fault flag or the overvoltage flag is 1. A fault reads as 1 and a healthy channel as 0.
- R7: While chip select is high, `sdo_oe` is 0, `sdo` is 0, and activity on `sclk` and `sdi` has no effect.
- R8: A frame that ends with a bit count other than 24 is dropped, and `out_en` keeps its previous value.
- R9: An active-low reset clears `out_en`, `sdo` and `sdo_oe`.
- R10: `out_en` changes only as the result of an accepted frame, or of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| fault_i | input | 16 | Per-channel fault flags, 1 = faulted |
| ovp_i | input | 1 | Supply overvoltage flag |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the `sdo` tristate driver |
| out_en | output | 16 | Channel enable register |

## Verification
The bench sends short frames (20 bits) and long frames (26 bits). A block that committed on any chip-select release, or that counted modulo the frame length, would overwrite the enables in these cases. It also changes the fault inputs in the middle of a frame: a design that read the flags live instead of taking a snapshot would return the new value. The upper eight command bits are set to ones, so a design that took the wrong slice of the word would load the wrong enables. Finally, the bench toggles `sclk` and `sdi` with chip select high and resets the block in the middle of a frame. A design that shifted while deselected, or that failed to clear its state on reset, would then drive `sdo` or change `out_en`.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int unsigned DEF_CHANNELS = 16;
    localparam int unsigned DEF_FRAME    = 24;
    localparam int unsigned DEF_SYNC     = 2;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } sw_edge_t;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output sw_pkg::sw_edge_t [W-1:0] ev
);
    localparam int unsigned DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int s = 1; s < DEPTH; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {DEPTH{RST_V}};
        else        st_q <= st_d;
    end

    for (genvar b = 0; b < W; b++) begin : g_edge
        assign ev[b].lvl  = st_q.pipe[STAGES-1][b];
        assign ev[b].rise = st_q.pipe[STAGES-1][b] & ~st_q.pipe[STAGES][b];
        assign ev[b].fall = ~st_q.pipe[STAGES-1][b] & st_q.pipe[STAGES][b];
    end
endmodule

// File: rtl/sw_serial_core.sv
module sw_serial_core #(
    parameter int unsigned FRAME = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             sdi,
    input  logic [FRAME-1:0] status_i,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             cmd_valid,
    output logic [FRAME-1:0] cmd
);
    localparam int unsigned CNTW = $clog2(FRAME + 2);
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(FRAME);
    localparam logic [CNTW-1:0] CNT_SAT  = CNTW'(FRAME + 1);

    typedef struct packed {
        logic [FRAME-1:0] rx;
        logic [FRAME-1:0] tx;
        logic [CNTW-1:0]  cnt;
        logic             sdo;
        logic             oe;
        logic             vld;
        logic [FRAME-1:0] cmd;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.oe  = active;
        if (cs_fall) begin
            st_d.tx  = status_i;
            st_d.rx  = '0;
            st_d.cnt = '0;
            st_d.sdo = 1'b0;
        end else if (active) begin
            if (sclk_fall) begin
                st_d.rx = {st_q.rx[FRAME-2:0], sdi};
                if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sclk_rise) begin
                st_d.sdo = st_q.tx[FRAME-1];
                st_d.tx  = {st_q.tx[FRAME-2:0], 1'b0};
            end
        end
        if (cs_rise && st_q.cnt == CNT_FULL) begin
            st_d.vld = 1'b1;
            st_d.cmd = st_q.rx;
        end
        if (!active) st_d.sdo = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo       = st_q.sdo;
    assign sdo_oe    = st_q.oe;
    assign cmd_valid = st_q.vld;
    assign cmd       = st_q.cmd;

    // R8: a frame of the wrong length never produces a command
    a_r8_no_short_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && st_q.cnt != CNT_FULL) |=> !cmd_valid);

    // R4: the transmit register holds the status present at chip-select fall
    a_r4_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (st_q.tx == $past(status_i)));

    // R3: a rising serial clock puts the pending top bit on sdo
    a_r3_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && active && !cs_fall) |=> (sdo == $past(st_q.tx[FRAME-1])));
endmodule

// File: rtl/sw_serial_port.sv
module sw_serial_port #(
    parameter int unsigned CHANNELS = sw_pkg::DEF_CHANNELS,
    parameter int unsigned FRAME    = sw_pkg::DEF_FRAME,
    parameter int unsigned SYNC     = sw_pkg::DEF_SYNC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                sdi,
    input  logic [CHANNELS-1:0] fault_i,
    input  logic                ovp_i,
    output logic                sdo,
    output logic                sdo_oe,
    output logic [CHANNELS-1:0] out_en
);
    localparam int unsigned PAD = FRAME - CHANNELS - 2;
    localparam int unsigned I_CS = 2, I_CK = 1, I_DI = 0;

    sw_pkg::sw_edge_t [2:0] ev;

    sw_sync #(.W(3), .STAGES(SYNC), .RST_V(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sclk, sdi}),
        .ev   (ev)
    );

    logic             active, cs_fall, cs_rise;
    logic [FRAME-1:0] status_w, cmd_w;
    logic             cmd_vld;

    assign active  = ~ev[I_CS].lvl;
    assign cs_fall = ev[I_CS].fall;
    assign cs_rise = ev[I_CS].rise;

    always_comb begin
        status_w = {(|fault_i) | ovp_i, ovp_i, {PAD{1'b0}}, fault_i};
    end

    sw_serial_core #(.FRAME(FRAME)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sclk_rise(ev[I_CK].rise),
        .sclk_fall(ev[I_CK].fall),
        .sdi      (ev[I_DI].lvl),
        .status_i (status_w),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .cmd_valid(cmd_vld),
        .cmd      (cmd_w)
    );

    typedef struct packed {
        logic [CHANNELS-1:0] en;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_vld) st_d.en = cmd_w[CHANNELS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_en = st_q.en;

    // R10: enables move only when the core delivers an accepted command
    a_r10_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> $stable(out_en));

    // R1: accepted command lands in the enable register
    a_r1_commit: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> (out_en == $past(cmd_w[CHANNELS-1:0])));

    // R7: deselected port releases and zeroes its serial output
    a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!sdo_oe && !sdo));
endmodule

// File: tb/sw_serial_port_tb.sv
module sw_serial_port_tb;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [15:0] fault_i = '0;
    logic        ovp_i = 1'b0;
    logic        sdo, sdo_oe;
    logic [15:0] out_en;

    int checks = 0, errors = 0;

    typedef struct {
        logic [23:0] status;
        logic [15:0] en;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];

    always #2.5 clk = ~clk;

    sw_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .fault_i(fault_i), .ovp_i(ovp_i), .sdo(sdo), .sdo_oe(sdo_oe), .out_en(out_en)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] stat(input logic [15:0] f, input logic ov);
        return {(|f) | ov, ov, 6'b0, f};
    endfunction

    // driver: runs one frame, pushes expected and observed items
    task automatic frame(input int nbits, input logic [23:0] cmd, input logic [23:0] exp_st,
                         input logic [15:0] exp_en, input bit chg, input logic [15:0] new_f,
                         input string tag);
        item_t e, a;
        logic [23:0] rcv = '0;
        cs_n = 1'b0;
        tick(HALF);
        if (chg) fault_i = new_f;
        check(sdo_oe === 1'b1, {tag, " R7 oe during frame"}, 32'(sdo_oe), 32'd1);
        for (int k = 0; k < nbits; k++) begin
            sdi = (k < 24) ? cmd[23-k] : 1'b0;
            sclk = 1'b1;
            tick(HALF);
            if (k < 24) rcv = {rcv[22:0], sdo};
            sclk = 1'b0;
            tick(HALF);
        end
        cs_n = 1'b1;
        tick(12);
        e.status = (nbits < 24) ? (exp_st >> (24 - nbits)) : exp_st;
        if (nbits < 24) rcv = rcv & ((24'h1 << nbits) - 24'h1);
        e.en = exp_en; e.tag = tag;
        a.status = rcv; a.en = out_en; a.tag = tag;
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    // monitor: pops and compares
    initial begin
        forever begin
            item_t e, a;
            wait (act_q.size() > 0);
            a = act_q.pop_front();
            e = exp_q.pop_front();
            check(a.status === e.status, {e.tag, " status word"}, 32'(a.status), 32'(e.status));
            check(a.en === e.en, {e.tag, " out_en"}, 32'(a.en), 32'(e.en));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(5);
        check(out_en === 16'h0, "R9 reset out_en", 32'(out_en), 0);
        check(sdo_oe === 1'b0 && sdo === 1'b0, "R9 reset sdo/oe", {30'b0, sdo_oe, sdo}, 0);
        rst_n = 1'b1;
        tick(10);
        check(sdo_oe === 1'b0, "R7 idle oe", 32'(sdo_oe), 0);

        frame(24, 24'h00A5A5, stat(16'h0, 0), 16'hA5A5, 0, 0, "R1 R2 R3 basic");
        fault_i = 16'h8001;
        frame(24, 24'hFF1234, stat(16'h8001, 0), 16'h1234, 0, 0, "R1 R5 R6 upper ignored");
        fault_i = 16'h0; ovp_i = 1'b1;
        frame(24, 24'h00FFFF, 24'hC00000, 16'hFFFF, 0, 0, "R5 R6 overvoltage");
        ovp_i = 1'b0; fault_i = 16'h0100;
        frame(24, 24'h000F0F, 24'h800100, 16'h0F0F, 1, 16'hFFFF, "R4 snapshot");
        frame(20, 24'h00AAAA, stat(16'hFFFF, 0), 16'h0F0F, 0, 0, "R8 short frame");
        frame(26, 24'h005555, stat(16'hFFFF, 0), 16'h0F0F, 0, 0, "R8 long frame");

        for (int i = 0; i < 30; i++) begin
            sdi = 1'($urandom);
            sclk = ~sclk;
            tick(HALF);
        end
        sclk = 1'b0;
        tick(HALF);
        check(out_en === 16'h0F0F, "R7 sclk ignored while deselected", 32'(out_en), 32'h0F0F);
        check(sdo_oe === 1'b0 && sdo === 1'b0, "R7 sdo quiet while deselected", {30'b0, sdo_oe, sdo}, 0);

        fault_i = 16'h0;
        frame(24, 24'h003C3C, stat(16'h0, 0), 16'h3C3C, 0, 0, "R1 R10 after idle toggling");

        cs_n = 1'b0;
        tick(HALF);
        for (int k = 0; k < 10; k++) begin
            sdi = k[0];
            sclk = 1'b1; tick(HALF);
            sclk = 1'b0; tick(HALF);
        end
        rst_n = 1'b0;
        tick(3);
        check(out_en === 16'h0, "R9 mid-frame reset", 32'(out_en), 0);
        rst_n = 1'b1;
        tick(4);
        cs_n = 1'b1;
        tick(12);
        check(out_en === 16'h0, "R8 R10 partial frame after reset", 32'(out_en), 0);

        frame(24, 24'h00C003, stat(16'h0, 0), 16'hC003, 0, 0, "R1 recovery");

        wait (act_q.size() == 0);
        tick(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule